// File: doc/BRIEF.md
# Cycle-Count Timeout Interrupt with Program Bank Steering

This block counts clock cycles and raises a level interrupt once a programmable timeout has elapsed. The timeout length comes from a four-bit switch setting that is captured while reset is held. A five-bit control value, already assembled by an upstream loader and presented with a write strobe, sets the mode. One bit of it freezes the counter and acknowledges the interrupt. The other bits choose how the program window is banked.

Banking has two modes. In the first, one 32 KB bank is picked by two control bits and is reported as a pair of adjacent 16 KB bank numbers. In the second, each 16 KB window takes its number from a per-window bank input, forced into the upper half of program space. With the default parameters the counter is 30 bits wide and the limit is `2^29 | (switch << 25)`. The largest switch setting therefore still fits inside the counter.

Top module: `cycleTimeoutIrq`

## Requirements
- R1: While the held control value has bit 4 clear, the counter advances by one on every clock. While bit 4 is set, it does not advance.
- R2: The limit is `2^(COUNT_W-1) | (switch << DIP_SHIFT)`. Starting from zero with counting enabled, the count of limit is reached on the limit-th counting clock. On that clock the counter returns to zero and `irqOut` rises.
- R3: A control write with bit 4 set clears the counter and drops `irqOut` on that clock. It wins over a limit event falling on the same clock.
- R4: A control write with bit 4 clear leaves both the counter and `irqOut` untouched.
- R5: With control bit 3 clear, `prgSelLo` is `2*ctrl[2:1]` and `prgSelHi` is `2*ctrl[2:1]+1`. Both are in 16 KB units, so together they form one 32 KB bank. Bit 4 has no effect on the selection.
- R6: With control bit 3 set, each window reads `8 | (bank & 7)` from its own bank input. Bit 3 of the bank input and control bits 2:1 are ignored.
- R7: `irqOut` is a level. Once set, it stays high across further counter wraps until a write with bit 4 set.
- R8: The switch setting is sampled only while `rst` is high. Changes while running do not alter the limit until the next reset.
- R9: After reset the control value is zero. The counter is zero and running, `irqOut` is low, and the selection is 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock; one count per edge |
| rst | input | 1 | Synchronous active-high reset; switch sampled while high |
| ctrlWrEn | input | 1 | Strobe: load `ctrlWrData` this clock |
| ctrlWrData | input | 5 | Assembled control value |
| dipSetting | input | 4 | Timeout switch setting |
| bankLoIn | input | BANK_W | 16 KB bank for the lower window in 16 KB mode |
| bankHiIn | input | BANK_W | 16 KB bank for the upper window in 16 KB mode |
| irqOut | output | 1 | Timeout interrupt, level |
| prgSelLo | output | BANK_W | Selected 16 KB bank, lower window |
| prgSelHi | output | BANK_W | Selected 16 KB bank, upper window |

## Verification
The limit event and the acknowledging write can land on the same clock, since both act on the counter and the interrupt. The bench provokes this by restarting the count and waiting one clock short of the limit. It then places a write with bit 4 set exactly on the limit edge. The design is judged correct if `irqOut` stays low on that edge and throughout a long frozen stretch that follows, which shows the clear took priority and no late interrupt slipped through.

// File: rtl/cycleTimeoutPkg.sv
package cycleTimeoutPkg;

  localparam int CTRL_W    = 5;
  localparam int HOLD_BIT  = 4;   // freeze + acknowledge
  localparam int MODE_BIT  = 3;   // 1: 16 KB windows, 0: one 32 KB bank
  localparam int SEL32_LSB = 1;
  localparam int SEL32_W   = 2;
  localparam int DIP_W     = 4;

  // strobes from control to the counting datapath
  typedef struct packed {
    logic clear;  // zero the counter and drop the interrupt
    logic tick;   // advance the counter this clock
  } cntStrobe_t;

endpackage

// File: rtl/timeoutCtrl.sv
module timeoutCtrl
  import cycleTimeoutPkg::*;
#(
  parameter int COUNT_W    = 30,
  parameter int DIP_SHIFT  = 25,
  parameter logic [CTRL_W-1:0] CTRL_RESET = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctrlWrEn,
  input  logic [CTRL_W-1:0]   ctrlWrData,
  input  logic [DIP_W-1:0]    dipSetting,
  output cntStrobe_t          strb,
  output logic [COUNT_W-1:0]  limit,
  output logic                mode16,
  output logic [SEL32_W-1:0]  sel32
);

  localparam logic [COUNT_W-1:0] TOP_BIT = {1'b1, {(COUNT_W-1){1'b0}}};
  localparam int PAD_W = COUNT_W - DIP_W;

  logic [CTRL_W-1:0] ctrlReg;
  logic [DIP_W-1:0]  dipReg;
  logic              unusedCtrlBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg <= CTRL_RESET;
      dipReg  <= dipSetting;   // switch captured only during reset
    end else if (ctrlWrEn) begin
      ctrlReg <= ctrlWrData;
    end
  end

  always_comb begin
    strb.clear = ctrlWrEn & ctrlWrData[HOLD_BIT];
    strb.tick  = ~ctrlReg[HOLD_BIT] & ~strb.clear;
  end

  assign limit         = TOP_BIT | ({{PAD_W{1'b0}}, dipReg} << DIP_SHIFT);
  assign mode16        = ctrlReg[MODE_BIT];
  assign sel32         = ctrlReg[SEL32_LSB +: SEL32_W];
  assign unusedCtrlBit = ctrlReg[0];

  AST_MODE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    ctrlWrEn |=> (mode16 == $past(ctrlWrData[MODE_BIT])));  // R5

  AST_HOLD_BLOCKS_TICK: assert property (@(posedge clk) disable iff (rst)
    (ctrlWrEn && ctrlWrData[HOLD_BIT]) |=> !strb.tick);  // R1

endmodule

// File: rtl/timeoutCount.sv
module timeoutCount
  import cycleTimeoutPkg::*;
#(
  parameter int COUNT_W = 30
) (
  input  logic               clk,
  input  logic               rst,
  input  cntStrobe_t         strb,
  input  logic [COUNT_W-1:0] limit,
  output logic               irq
);

  localparam logic [COUNT_W-1:0] ONE = {{(COUNT_W-1){1'b0}}, 1'b1};

  logic [COUNT_W-1:0] count;
  logic [COUNT_W-1:0] nextCount;
  logic               hitLimit;

  always_comb begin
    nextCount = count + ONE;
    hitLimit  = (nextCount >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      irq   <= 1'b0;
    end else if (strb.clear) begin
      count <= '0;
      irq   <= 1'b0;
    end else if (strb.tick) begin
      if (hitLimit) begin
        count <= '0;
        irq   <= 1'b1;
      end else begin
        count <= nextCount;
      end
    end
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    strb.clear |=> (count == '0 && !irq));  // R3

  AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!strb.tick && !strb.clear) |=> $stable(count));  // R1

  AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (strb.tick && (count != limit - ONE)) |=> (count == $past(count) + ONE));  // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count < limit);  // R2

  AST_IRQ_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(count) == limit - ONE && count == '0));  // R2

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (irq && !strb.clear) |=> irq);  // R7

endmodule

// File: rtl/prgBankSel.sv
module prgBankSel
  import cycleTimeoutPkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode16,
  input  logic [SEL32_W-1:0] sel32,
  input  logic [BANK_W-1:0]  bankLoIn,
  input  logic [BANK_W-1:0]  bankHiIn,
  output logic [BANK_W-1:0]  prgSelLo,
  output logic [BANK_W-1:0]  prgSelHi
);

  localparam int PAD_W = BANK_W - SEL32_W - 1;
  localparam logic [BANK_W-1:0] ONE = {{(BANK_W-1){1'b0}}, 1'b1};

  logic [BANK_W-1:0] bankIn [2];
  logic [BANK_W-1:0] prgSel [2];
  logic              unusedBankTop;

  assign bankIn[0]     = bankLoIn;
  assign bankIn[1]     = bankHiIn;
  assign unusedBankTop = bankLoIn[BANK_W-1] ^ bankHiIn[BANK_W-1];

  for (genvar w = 0; w < 2; w++) begin : gWin
    localparam logic HALF = (w == 0) ? 1'b0 : 1'b1;
    always_comb begin
      if (mode16)
        prgSel[w] = {1'b1, bankIn[w][BANK_W-2:0]};
      else
        prgSel[w] = {{PAD_W{1'b0}}, sel32, HALF};
    end
  end

  assign prgSelLo = prgSel[0];
  assign prgSelHi = prgSel[1];

  AST_UPPER_HALF_16K: assert property (@(posedge clk) disable iff (rst)
    mode16 |-> (prgSelLo[BANK_W-1] && prgSelHi[BANK_W-1]));  // R6

  AST_32K_ADJACENT: assert property (@(posedge clk) disable iff (rst)
    !mode16 |-> (prgSelHi == prgSelLo + ONE && !prgSelLo[0]));  // R5

endmodule

// File: rtl/cycleTimeoutIrq.sv
module cycleTimeoutIrq
  import cycleTimeoutPkg::*;
#(
  parameter int COUNT_W   = 30,
  parameter int DIP_SHIFT = 25,
  parameter int BANK_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrlWrEn,
  input  logic [4:0]        ctrlWrData,
  input  logic [3:0]        dipSetting,
  input  logic [BANK_W-1:0] bankLoIn,
  input  logic [BANK_W-1:0] bankHiIn,
  output logic              irqOut,
  output logic [BANK_W-1:0] prgSelLo,
  output logic [BANK_W-1:0] prgSelHi
);

  cntStrobe_t         strb;
  logic [COUNT_W-1:0] limit;
  logic               mode16;
  logic [SEL32_W-1:0] sel32;

  timeoutCtrl #(
    .COUNT_W   (COUNT_W),
    .DIP_SHIFT (DIP_SHIFT),
    .CTRL_RESET('0)
  ) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .ctrlWrEn  (ctrlWrEn),
    .ctrlWrData(ctrlWrData),
    .dipSetting(dipSetting),
    .strb      (strb),
    .limit     (limit),
    .mode16    (mode16),
    .sel32     (sel32)
  );

  timeoutCount #(
    .COUNT_W(COUNT_W)
  ) uCount (
    .clk  (clk),
    .rst  (rst),
    .strb (strb),
    .limit(limit),
    .irq  (irqOut)
  );

  prgBankSel #(
    .BANK_W(BANK_W)
  ) uBank (
    .clk     (clk),
    .rst     (rst),
    .mode16  (mode16),
    .sel32   (sel32),
    .bankLoIn(bankLoIn),
    .bankHiIn(bankHiIn),
    .prgSelLo(prgSelLo),
    .prgSelHi(prgSelHi)
  );

endmodule

// File: tb/tb_cycleTimeoutIrq.sv
`timescale 1ns/1ps
module tb_cycleTimeoutIrq;

  localparam int COUNT_W   = 8;
  localparam int DIP_SHIFT = 3;
  localparam int BANK_W    = 4;
  localparam int NVEC      = 9;

  // {ctrl[4:0], bankLo, bankHi, expLo, expHi}
  localparam logic [20:0] VEC [NVEC] = '{
    {5'h00, 4'h0, 4'h0, 4'h0, 4'h1},
    {5'h02, 4'h0, 4'h0, 4'h2, 4'h3},
    {5'h04, 4'hF, 4'hF, 4'h4, 4'h5},
    {5'h06, 4'h3, 4'h2, 4'h6, 4'h7},
    {5'h16, 4'h0, 4'h0, 4'h6, 4'h7},
    {5'h08, 4'h0, 4'h7, 4'h8, 4'hF},
    {5'h08, 4'hF, 4'h9, 4'hF, 4'h9},
    {5'h0E, 4'h3, 4'h5, 4'hB, 4'hD},
    {5'h1A, 4'h6, 4'h2, 4'hE, 4'hA}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ctrlWrEn = 1'b0;
  logic [4:0]        ctrlWrData = '0;
  logic [3:0]        dipSetting = 4'd4;
  logic [BANK_W-1:0] bankLoIn = '0;
  logic [BANK_W-1:0] bankHiIn = '0;
  logic              irqOut;
  logic [BANK_W-1:0] prgSelLo;
  logic [BANK_W-1:0] prgSelHi;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  cycleTimeoutIrq #(
    .COUNT_W(COUNT_W), .DIP_SHIFT(DIP_SHIFT), .BANK_W(BANK_W)
  ) dut (
    .clk(clk), .rst(rst), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .dipSetting(dipSetting), .bankLoIn(bankLoIn), .bankHiIn(bankHiIn),
    .irqOut(irqOut), .prgSelLo(prgSelLo), .prgSelHi(prgSelHi)
  );

  always #4 clk = ~clk;

  function automatic int limitOf(input int dip);
    return (1 << (COUNT_W - 1)) | (dip << DIP_SHIFT);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [3:0] dip);
    @(negedge clk);
    rst = 1'b1;
    ctrlWrEn = 1'b0;
    dipSetting = dip;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic writeCtrl(input logic [4:0] v);
    @(negedge clk);
    ctrlWrEn = 1'b1;
    ctrlWrData = v;
    @(posedge clk);
    #1;
    ctrlWrEn = 1'b0;
  endtask

  task automatic measureIrq(output int n);
    n = 0;
    do begin
      @(posedge clk);
      #1;
      n++;
    end while (!irqOut && n < 1000);
  endtask

  initial begin
    #(8.0 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    int part;

    // R9 reset state
    doReset(4'd4);
    #1;
    check(irqOut == 1'b0, "R9 irq after reset", irqOut, 0);
    check(prgSelLo == 4'd0 && prgSelHi == 4'd1, "R9 selection after reset",
          {prgSelLo, prgSelHi}, 8'h01);

    // R5 / R6 table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [20:0] v;
      v = VEC[i];
      bankLoIn = v[15:12];
      bankHiIn = v[11:8];
      writeCtrl(v[20:16]);
      check(prgSelLo == v[7:4], v[19] ? "R6 lower window" : "R5 lower window",
            prgSelLo, v[7:4]);
      check(prgSelHi == v[3:0], v[19] ? "R6 upper window" : "R5 upper window",
            prgSelHi, v[3:0]);
    end

    // R2 and R8: limit from switch captured at reset, later change ignored
    doReset(4'd4);
    dipSetting = 4'd15;
    measureIrq(n);
    check(n == limitOf(4), "R2 R8 cycles to irq, switch 4", n, limitOf(4));

    // R7 level held across another wrap
    repeat (200) @(posedge clk);
    #1;
    check(irqOut == 1'b1, "R7 irq held", irqOut, 1);

    // R4 write with bit 4 clear keeps irq
    writeCtrl(5'h08);
    check(irqOut == 1'b1, "R4 irq kept on non-clearing write", irqOut, 1);

    // R3 acknowledge
    writeCtrl(5'h10);
    check(irqOut == 1'b0, "R3 irq dropped by clearing write", irqOut, 0);

    // R1 frozen while bit 4 held
    repeat (300) @(posedge clk);
    #1;
    check(irqOut == 1'b0, "R1 no irq while frozen", irqOut, 0);

    // R4 counter kept across a non-clearing write mid-count
    writeCtrl(5'h00);
    repeat (20) @(posedge clk);
    writeCtrl(5'h08);
    part = 21;
    measureIrq(n);
    check(part + n == limitOf(4), "R4 count kept across write", part + n, limitOf(4));

    // R3 collision: clearing write lands on the limit edge
    writeCtrl(5'h10);
    writeCtrl(5'h00);
    repeat (limitOf(4) - 1) @(posedge clk);
    #1;
    check(irqOut == 1'b0, "R2 no irq before limit", irqOut, 0);
    writeCtrl(5'h10);
    check(irqOut == 1'b0, "R3 clear wins over limit", irqOut, 0);
    repeat (400) @(posedge clk);
    #1;
    check(irqOut == 1'b0, "R1 R3 no late irq", irqOut, 0);

    // R8 new switch taken at next reset
    doReset(4'd15);
    #1;
    check(prgSelLo == 4'd0 && prgSelHi == 4'd1, "R9 selection after second reset",
          {prgSelLo, prgSelHi}, 8'h01);
    measureIrq(n);
    check(n == limitOf(15), "R8 cycles to irq, switch 15", n, limitOf(15));

    // R2 smallest limit
    doReset(4'd0);
    measureIrq(n);
    check(n == limitOf(0), "R2 cycles to irq, switch 0", n, limitOf(0));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule